// File: doc/BRIEF.md
# SPI Flash Read Window

This block is a read-only bus slave that places an external serial flash behind a 16 MiB processor address window. Each bus read becomes one serial read frame on chip select 0. The frame carries a read command, a 24-bit flash address and 32 data clocks. The four bytes that come back are packed into one big-endian word and returned with a one-cycle ready pulse. The SPI clock is divided down from the system clock by a field held in a control register.

Out of reset only the low 4 MiB of flash is visible, and it repeats four times across the window, so the boot vector at window offset `0xC00000` reads flash offset 0. Setting the remap-disable bit widens the map to the whole 16 MiB. Clearing the function-select bit takes the pins away from the read engine and hands them to a software bit-bang port.

Top module: `spi_flash_window`

## Requirements
- R1: With the remap-disable bit at 0 (its reset value), the flash address equals the bus address with bits 23:22 forced to zero. The four 4 MiB quarters of the window are mirrors of one another.
- R2: Writing control register (`cfg_sel_i`=1) with bit 8 set maps the full 16 MiB: the flash address equals the 24-bit bus address.
- R3: A read frame drives CS0 low, sends the byte 0x03, then sends the 24-bit flash address high byte first, clocks 32 data bits, and releases CS0. Each frame carries exactly 64 SCK rising edges.
- R4: SPI mode 3. SCK idles high and is high when CS0 falls. MOSI changes only while SCK is low, and every byte is sent MSB first.
- R5: The first data byte received lands in `bus_rdata_o[31:24]` and the fourth in bits 7:0. Data are sampled on SCK rising edges.
- R6: Mapped fetches use only CS0. While the window is enabled, CS1 and CS2 stay high.
- R7: Control bits [DIV_W-1:0] hold a value d, which resets to 1. SCK stays high for d+1 system clocks and low for d+1 system clocks, giving a period of 2(d+1) clocks.
- R8: `bus_ready_o` is a one-cycle pulse. For a mapped read it comes only after the fourth data byte has been captured and CS0 has returned high. A request raised while a frame is in progress is ignored: it starts no frame and does not change the returned data.
- R9: A write request (`bus_we_i`=1) raises `bus_ready_o` on the next cycle and causes no SPI activity.
- R10: Function-select register (`cfg_sel_i`=0) bit 0 resets to 1. When it is 0, the SPI pins follow `bb_cs_n_i`, `bb_sck_i` and `bb_mosi_i`, and a read returns 0 with ready on the next cycle and no frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_req_i | input | 1 | Bus request, sampled only while idle |
| bus_we_i | input | 1 | 1 = write request (ignored), 0 = read |
| bus_addr_i | input | 24 | Byte offset within the 16 MiB window |
| bus_ready_o | output | 1 | One-cycle completion pulse |
| bus_rdata_o | output | 32 | Read word, valid while ready is high |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_sel_i | input | 1 | 0 = function select, 1 = control |
| cfg_wdata_i | input | 32 | Register write data |
| bb_cs_n_i | input | 3 | Bit-bang chip selects |
| bb_sck_i | input | 1 | Bit-bang SPI clock |
| bb_mosi_i | input | 1 | Bit-bang serial data out |
| spi_cs_n_o | output | 3 | Flash chip selects, active low |
| spi_sck_o | output | 1 | SPI clock |
| spi_mosi_o | output | 1 | Serial data to flash |
| spi_miso_i | input | 1 | Serial data from flash |

## Verification
The bench reads through the boot mirror at `0xC00010`. A design that ignored the mirror would send address `0xC00010` rather than `0x000010`, and after remap is enabled the same read must reach the high address. A flash model whose bytes depend on every address bit would expose wrong byte packing as a swapped word, and a misplaced bit shift as a different command or address. The bench times SCK high and low phases with a non-default divider to catch an off-by-one in the divider. It fires a second request in the middle of a frame, where a design that accepted it would start a second frame or return the wrong word. Writes and disabled-window reads must complete in one cycle without lowering CS0, and bit-bang values must reach the pins.

// File: rtl/sfw_pkg.sv
package sfw_pkg;
  localparam logic [7:0] READ_CMD  = 8'h03;
  localparam int         REMAP_BIT = 8;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_XFER,
    ST_DONE
  } sfw_state_e;
endpackage

// File: rtl/sfw_cfg_regs.sv
module sfw_cfg_regs #(
  parameter int DIV_W   = 6,
  parameter int DIV_RST = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic             sel_i,
  input  logic [31:0]      wdata_i,
  output logic             map_en_o,
  output logic             remap_dis_o,
  output logic [DIV_W-1:0] div_o
);
  import sfw_pkg::*;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      map_en_o    <= 1'b1;
      remap_dis_o <= 1'b0;
      div_o       <= DIV_W'(DIV_RST);
    end else if (we_i) begin
      if (!sel_i) begin
        map_en_o <= wdata_i[0];
      end else begin
        remap_dis_o <= wdata_i[REMAP_BIT];
        div_o       <= wdata_i[DIV_W-1:0];
      end
    end
  end
endmodule

// File: rtl/sfw_sck_gen.sv
module sfw_sck_gen #(
  parameter int DIV_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!run_i)  cnt_q <= '0;
    else if (tick_o)  cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/sfw_serdes.sv
module sfw_serdes #(
  parameter int WORD_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [WORD_W-1:0] frame_i,
  input  logic              active_i,
  input  logic              tick_i,
  input  logic              miso_i,
  output logic              sck_o,
  output logic              mosi_o,
  output logic              last_o,
  output logic [WORD_W-1:0] rx_o
);
  localparam int TOTAL = 2 * WORD_W;
  localparam int CNT_W = $clog2(TOTAL);

  logic [WORD_W-1:0] tx_q;
  logic [CNT_W-1:0]  cnt_q;

  // last rising edge of the frame
  assign last_o = active_i && tick_i && !sck_o && (cnt_q == CNT_W'(TOTAL - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q   <= '0;
      cnt_q  <= '0;
      sck_o  <= 1'b1;
      mosi_o <= 1'b0;
      rx_o   <= '0;
    end else if (load_i) begin
      tx_q  <= frame_i;
      cnt_q <= '0;
      sck_o <= 1'b1;
    end else if (active_i && tick_i) begin
      if (sck_o) begin
        sck_o  <= 1'b0;
        mosi_o <= tx_q[WORD_W-1];
        tx_q   <= {tx_q[WORD_W-2:0], 1'b0};
      end else begin
        sck_o <= 1'b1;
        if (cnt_q >= CNT_W'(WORD_W)) rx_o <= {rx_o[WORD_W-2:0], miso_i};
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/spi_flash_window.sv
module spi_flash_window
  import sfw_pkg::*;
#(
  parameter int DIV_W   = 6,
  parameter int DIV_RST = 1,
  parameter int ADDR_W  = 24,
  parameter int BOOT_W  = 22
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_req_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  output logic              bus_ready_o,
  output logic [31:0]       bus_rdata_o,
  input  logic              cfg_we_i,
  input  logic              cfg_sel_i,
  input  logic [31:0]       cfg_wdata_i,
  input  logic [2:0]        bb_cs_n_i,
  input  logic              bb_sck_i,
  input  logic              bb_mosi_i,
  output logic [2:0]        spi_cs_n_o,
  output logic              spi_sck_o,
  output logic              spi_mosi_o,
  input  logic              spi_miso_i
);
  localparam int WORD_W  = 32;
  localparam int FRAME_W = 8 + ADDR_W;

  sfw_state_e        state_q;
  logic              map_en, remap_dis, tick, busy, load, frame_end;
  logic [DIV_W-1:0]  div;
  logic [ADDR_W-1:0] boot_addr, flash_addr;
  logic              cs_q, ready_q, sck, mosi;
  logic [31:0]       rdata_q;
  logic [WORD_W-1:0] rx;

  sfw_cfg_regs #(.DIV_W(DIV_W), .DIV_RST(DIV_RST)) u_regs (
    .clk_i, .rst_ni,
    .we_i       (cfg_we_i),
    .sel_i      (cfg_sel_i),
    .wdata_i    (cfg_wdata_i),
    .map_en_o   (map_en),
    .remap_dis_o(remap_dis),
    .div_o      (div)
  );

  generate
    if (BOOT_W < ADDR_W) begin : g_mirror
      assign boot_addr = {{(ADDR_W-BOOT_W){1'b0}}, bus_addr_i[BOOT_W-1:0]};
    end else begin : g_flat
      assign boot_addr = bus_addr_i;
    end
  endgenerate

  assign flash_addr = remap_dis ? bus_addr_i : boot_addr;
  assign busy       = (state_q != ST_IDLE);
  assign load       = !busy && bus_req_i && !bus_we_i && map_en;

  sfw_sck_gen #(.DIV_W(DIV_W)) u_sck (
    .clk_i, .rst_ni,
    .run_i (busy),
    .div_i (div),
    .tick_o(tick)
  );

  sfw_serdes #(.WORD_W(WORD_W)) u_serdes (
    .clk_i, .rst_ni,
    .load_i  (load),
    .frame_i (FRAME_W'({READ_CMD, flash_addr})),
    .active_i(state_q == ST_XFER),
    .tick_i  (tick),
    .miso_i  (spi_miso_i),
    .sck_o   (sck),
    .mosi_o  (mosi),
    .last_o  (frame_end),
    .rx_o    (rx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cs_q    <= 1'b1;
      ready_q <= 1'b0;
      rdata_q <= '0;
    end else begin
      ready_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (bus_req_i) begin
          if (bus_we_i) begin
            ready_q <= 1'b1;
          end else if (!map_en) begin
            ready_q <= 1'b1;
            rdata_q <= '0;
          end else begin
            cs_q    <= 1'b0;
            state_q <= ST_XFER;
          end
        end
        ST_XFER: if (frame_end) state_q <= ST_DONE;
        ST_DONE: if (tick) begin
          cs_q    <= 1'b1;
          ready_q <= 1'b1;
          rdata_q <= rx;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign bus_ready_o = ready_q;
  assign bus_rdata_o = rdata_q;
  assign spi_cs_n_o  = map_en ? {2'b11, cs_q} : bb_cs_n_i;
  assign spi_sck_o   = map_en ? sck  : bb_sck_i;
  assign spi_mosi_o  = map_en ? mosi : bb_mosi_i;
endmodule

// File: rtl/sfw_checker.sv
module sfw_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       map_en_i,
  input logic       busy_i,
  input logic       bus_req_i,
  input logic       bus_we_i,
  input logic       bus_ready_o,
  input logic [2:0] spi_cs_n_o,
  input logic       spi_sck_o,
  input logic       spi_mosi_o
);
  // R6
  other_cs_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    map_en_i |-> spi_cs_n_o[2:1] == 2'b11);

  // R4
  sck_idle_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (map_en_i && spi_cs_n_o[0]) |-> spi_sck_o);

  // R4
  mosi_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (map_en_i && $past(map_en_i) && !spi_cs_n_o[0] && !$past(spi_cs_n_o[0])
     && spi_sck_o && $past(spi_sck_o)) |-> $stable(spi_mosi_o));

  // R8
  ready_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_ready_o |=> !bus_ready_o);

  // R8
  ready_cs_released_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_ready_o && map_en_i) |-> spi_cs_n_o[0]);

  // R9
  write_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_i && bus_we_i && !busy_i) |=> (bus_ready_o && !busy_i));
endmodule

bind spi_flash_window sfw_checker u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .map_en_i   (map_en),
  .busy_i     (busy),
  .bus_req_i  (bus_req_i),
  .bus_we_i   (bus_we_i),
  .bus_ready_o(bus_ready_o),
  .spi_cs_n_o (spi_cs_n_o),
  .spi_sck_o  (spi_sck_o),
  .spi_mosi_o (spi_mosi_o)
);

// File: tb/spi_flash_window_test.sv
`timescale 1ns/1ps
module spi_flash_window_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [23:0] addr = '0;
  logic        ready;
  logic [31:0] rdata;
  logic        cfg_we = 1'b0, cfg_sel = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [2:0]  bb_cs_n = 3'b111;
  logic        bb_sck = 1'b1, bb_mosi = 1'b0;
  logic [2:0]  cs_n;
  logic        sck, mosi;
  logic        miso = 1'b0;

  int n_chk = 0, n_bad = 0;

  // flash model state
  int          rc = 0;
  int          frames = 0;
  int          cs_bad = 0;
  logic        sck_at_start = 1'b1;
  logic [31:0] sh = '0;
  time         t_rise = 0, t_fall = 0, lo_time = 0, hi_time = 0;

  always #10 clk = ~clk;

  spi_flash_window uut (
    .clk_i(clk), .rst_ni(rst_n),
    .bus_req_i(req), .bus_we_i(we), .bus_addr_i(addr),
    .bus_ready_o(ready), .bus_rdata_o(rdata),
    .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel), .cfg_wdata_i(cfg_wdata),
    .bb_cs_n_i(bb_cs_n), .bb_sck_i(bb_sck), .bb_mosi_i(bb_mosi),
    .spi_cs_n_o(cs_n), .spi_sck_o(sck), .spi_mosi_o(mosi),
    .spi_miso_i(miso)
  );

  function automatic logic [7:0] fbyte(input logic [23:0] a);
    return a[7:0] ^ a[15:8] ^ (a[23:16] * 8'd37) ^ 8'hA5;
  endfunction

  function automatic logic [31:0] fword(input logic [23:0] a);
    return {fbyte(a), fbyte(a + 24'd1), fbyte(a + 24'd2), fbyte(a + 24'd3)};
  endfunction

  always @(negedge cs_n[0]) begin
    rc = 0;
    frames++;
    sck_at_start = sck;
  end

  always @(posedge sck) if (!cs_n[0]) begin
    if (rc < 32) sh = {sh[30:0], mosi};
    if (cs_n[2:1] != 2'b11) cs_bad++;
    lo_time = $time - t_fall;
    t_rise = $time;
    rc++;
  end

  always @(negedge sck) if (!cs_n[0]) begin
    if (rc > 0) hi_time = $time - t_rise;
    t_fall = $time;
    if (rc >= 32 && rc < 64) begin
      automatic int k = rc - 32;
      automatic logic [7:0] b = fbyte(sh[23:0] + 24'(k / 8));
      miso = b[7 - (k % 8)];
    end
  end

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input logic sel, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic bus_read(input logic [23:0] a, output logic [31:0] d, output int cyc);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a;
    @(negedge clk);
    req = 1'b0;
    cyc = 1;
    while (!ready && cyc < 5000) begin
      @(negedge clk);
      cyc++;
    end
    d = rdata;
  endtask

  task automatic t_reset;
    check(ready == 1'b0, "R8 reset ready", 64'(ready), 0);
    check(cs_n == 3'b111, "R6 reset cs", 64'(cs_n), 64'h7);
    check(sck == 1'b1, "R4 reset sck idle", 64'(sck), 1);
    check(rdata == 32'h0, "R5 reset rdata", 64'(rdata), 0);
  endtask

  task automatic t_mirror_read(input logic [23:0] a);
    logic [31:0] d; int cyc; int f0;
    logic [23:0] fa;
    fa = {2'b00, a[21:0]};
    f0 = frames;
    bus_read(a, d, cyc);
    check(frames == f0 + 1, "R3 one frame", 64'(frames - f0), 1);
    check(sh[31:24] == 8'h03, "R3 command byte", 64'(sh[31:24]), 64'h03);
    check(sh[23:0] == fa, "R1 mirrored address", 64'(sh[23:0]), 64'(fa));
    check(rc == 64, "R3 clock count", 64'(rc), 64);
    check(sck_at_start == 1'b1, "R4 sck high at select", 64'(sck_at_start), 1);
    check(d == fword(fa), "R5 big-endian word", 64'(d), 64'(fword(fa)));
    check(cs_n[0] == 1'b1, "R8 cs released at ready", 64'(cs_n[0]), 1);
    check(cs_bad == 0, "R6 only cs0", 64'(cs_bad), 0);
  endtask

  task automatic t_remap_read(input logic [23:0] a);
    logic [31:0] d; int cyc;
    bus_read(a, d, cyc);
    check(sh[23:0] == a, "R2 full address", 64'(sh[23:0]), 64'(a));
    check(d == fword(a), "R2 full map data", 64'(d), 64'(fword(a)));
  endtask

  task automatic t_divider(input int dv);
    logic [31:0] d; int cyc;
    cfg_write(1'b1, 32'(dv) | (32'h1 << 8));
    bus_read(24'h123456, d, cyc);
    check(lo_time == time'((dv + 1) * 20), "R7 sck low time", 64'(lo_time), 64'((dv + 1) * 20));
    check(hi_time == time'((dv + 1) * 20), "R7 sck high time", 64'(hi_time), 64'((dv + 1) * 20));
    check(d == fword(24'h123456), "R7 data at divider", 64'(d), 64'(fword(24'h123456)));
  endtask

  task automatic t_busy_ignore;
    logic [31:0] d; int cyc; int f0;
    f0 = frames;
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = 24'h0ABCDE;
    @(negedge clk);
    req = 1'b0;
    repeat (20) @(negedge clk);
    req = 1'b1; addr = 24'h3F0001;
    @(negedge clk);
    req = 1'b0;
    cyc = 0;
    while (!ready && cyc < 5000) begin
      @(negedge clk);
      cyc++;
    end
    d = rdata;
    check(d == fword(24'h0ABCDE), "R8 busy request ignored data", 64'(d), 64'(fword(24'h0ABCDE)));
    repeat (40) @(negedge clk);
    check(frames == f0 + 1, "R8 busy request no frame", 64'(frames - f0), 1);
    check(ready == 1'b0, "R8 no extra ready", 64'(ready), 0);
  endtask

  task automatic t_write_ignored;
    int f0;
    f0 = frames;
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = 24'h000100;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
    check(ready == 1'b1, "R9 write ready next cycle", 64'(ready), 1);
    check(cs_n[0] == 1'b1, "R9 write no select", 64'(cs_n[0]), 1);
    @(negedge clk);
    check(ready == 1'b0, "R8 write ready single pulse", 64'(ready), 0);
    repeat (10) @(negedge clk);
    check(frames == f0, "R9 write no frame", 64'(frames - f0), 0);
  endtask

  task automatic t_bitbang;
    int f0;
    logic [31:0] d;
    f0 = frames;
    cfg_write(1'b0, 32'h0);
    bb_cs_n = 3'b101; bb_sck = 1'b0; bb_mosi = 1'b1;
    @(negedge clk);
    check(cs_n == 3'b101, "R10 bit-bang cs", 64'(cs_n), 64'h5);
    check(sck == 1'b0, "R10 bit-bang sck", 64'(sck), 0);
    check(mosi == 1'b1, "R10 bit-bang mosi", 64'(mosi), 1);
    bb_cs_n = 3'b111; bb_sck = 1'b1; bb_mosi = 1'b0;
    req = 1'b1; we = 1'b0; addr = 24'h000040;
    @(negedge clk);
    req = 1'b0;
    d = rdata;
    check(ready == 1'b1, "R10 disabled read ready", 64'(ready), 1);
    check(d == 32'h0, "R10 disabled read zero", 64'(d), 0);
    repeat (5) @(negedge clk);
    check(frames == f0, "R10 disabled read no frame", 64'(frames - f0), 0);
    cfg_write(1'b0, 32'h1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_mirror_read(24'hC00010);
    t_mirror_read(24'h412345);
    t_mirror_read(24'h3FFFFE);
    t_write_ignored();
    cfg_write(1'b1, 32'h0000_0101);
    t_remap_read(24'hC00010);
    t_remap_read(24'hFFFFFC);
    t_divider(3);
    t_divider(0);
    cfg_write(1'b1, 32'h1);
    t_busy_ignore();
    t_bitbang();
    t_mirror_read(24'h800000);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule